// File: doc/BRIEF.md
# Banked Register Stack File

The block is a register file organised as a stack. It holds four banks of eight data registers. Entries are addressed relative to a top pointer. A single shared status word holds the top pointer and one valid tag for each of the eight stack slots. Each bank stores its own data.

A command input drives the block one operation per cycle: push, pop, add-and-pop, bank select, initialise, and save or restore of the status word. The data output always shows the selected bank's register under the top pointer, along with that slot's tag. Switching banks changes only which data array is seen. The pointer and tags stay as they were, so the earlier view of a bank comes back only after a saved status word is restored. Bank 3 is meant to serve as a scratchpad, but it can be selected like any other bank.

Top module: `stack_bank_file`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) sets the following, with no data register cleared:
  - the top pointer to 0;
  - all eight tags to empty;
  - the selected bank to 0;
  - both flags to 0.
- R2: Push (command code 1) moves the top pointer down by one modulo 8. It writes `din` into the selected bank at the new top and marks that slot valid. From the next cycle, `tos_data` shows `din` and `tos_valid` is 1.
- R3: A push whose target slot is already valid raises `ovf_flag` for exactly the cycle after the command. The write still happens.
- R4: Pop (command code 2) clears the tag of the top slot and moves the pointer up by one modulo 8. If that slot was empty, `unf_flag` is raised for the cycle after the command.
- R5: Add-and-pop (command code 3) writes the sum of the top and next entries, modulo 2^W, into the next slot of the selected bank. It then pops. If either slot was empty, `unf_flag` is raised.
- R6: Bank select (command code 4) takes the bank number from `din[1:0]`, and any of banks 0 to 3 may be chosen. It leaves the pointer and tags unchanged. The bank only changes on this command.
- R7: The data of a bank is unaltered by any command issued while another bank is selected.
- R8: Initialise (command code 5) sets the pointer to 0 and all tags to empty. It keeps the stored data and the selected bank.
- R9: Save (command code 6) copies the 11-bit status word (top pointer and 8 tags) into a holding register. Restore (command code 7) loads it back, so that entries pushed before the save reappear in their original stack order.
- R10: Command code 0 is a no-operation and leaves all state unchanged. Both flags are never raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Command code (see R2 to R10) |
| din | input | W | Push data; bits [1:0] carry the bank number for bank select |
| tos_data | output | W | Selected bank's register at the top pointer |
| tos_valid | output | 1 | Tag of the top slot |
| bank_sel | output | 2 | Currently selected bank |
| ovf_flag | output | 1 | Push onto a valid slot, one cycle |
| unf_flag | output | 1 | Pop or add from an empty slot, one cycle |

## Verification
A directed sequence exercises the cases that separate shared state from per-bank state:
- It fills one bank, saves the status, then switches bank and initialises.
- It computes in the second bank, then switches back and restores.
- It then expects the first bank's three values in order. A design that saved the pointer per bank, or cleared data on initialise, fails here.

Nine pushes after an initialise separate correct overflow detection from wrap-around. A pop and an add on an empty stack expose the underflow paths. A long run of random commands, biased toward push and pop with occasional bank switches, is compared every cycle against a behavioural model. That model tracks, per bank and slot, whether the value is known.

// File: rtl/stk_pkg.sv
// Package: command codes shared by the stack file and its bench-facing top.
// Assumes a 3-bit command bus; every code has a defined meaning.
package stk_pkg;
    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_PUSH    = 3'd1,
        CMD_POP     = 3'd2,
        CMD_ADDP    = 3'd3,
        CMD_BANK    = 3'd4,
        CMD_INIT    = 3'd5,
        CMD_SAVE    = 3'd6,
        CMD_RESTORE = 3'd7
    } cmd_e;
endpackage

// File: rtl/stk_status_ctl.sv
// Module: stk_status_ctl
// Holds the shared status word (top pointer plus one tag per slot), its
// save register and the one-cycle overflow/underflow flags.
// Assumes at most one command per cycle; DEPTH is a power of two so the
// pointer wraps naturally.
module stk_status_ctl #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_push,
    input  logic             do_pop,
    input  logic             do_addp,
    input  logic             do_init,
    input  logic             do_save,
    input  logic             do_rest,
    output logic [PW-1:0]    top,
    output logic [PW-1:0]    top_dn,
    output logic [PW-1:0]    top_up,
    output logic [DEPTH-1:0] tags,
    output logic             ovf,
    output logic             unf
);
    typedef struct packed {
        logic [PW-1:0]    ptr;
        logic [DEPTH-1:0] tag;
    } stat_t;

    stat_t cur_q, saved_q;

    // Neighbouring slot indices around the top pointer.
    always_comb begin
        top_dn = cur_q.ptr - 1'b1;
        top_up = cur_q.ptr + 1'b1;
    end

    assign top  = cur_q.ptr;
    assign tags = cur_q.tag;

    // Status word update per command, flags pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            saved_q <= '0;
            ovf     <= 1'b0;
            unf     <= 1'b0;
        end else begin
            ovf <= 1'b0;
            unf <= 1'b0;
            if (do_push) begin
                cur_q.ptr         <= top_dn;
                cur_q.tag[top_dn] <= 1'b1;
                ovf               <= cur_q.tag[top_dn];
            end else if (do_pop) begin
                unf                  <= ~cur_q.tag[cur_q.ptr];
                cur_q.tag[cur_q.ptr] <= 1'b0;
                cur_q.ptr            <= top_up;
            end else if (do_addp) begin
                unf                  <= ~cur_q.tag[cur_q.ptr] | ~cur_q.tag[top_up];
                cur_q.tag[cur_q.ptr] <= 1'b0;
                cur_q.ptr            <= top_up;
            end else if (do_init) begin
                cur_q <= '0;
            end else if (do_save) begin
                saved_q <= cur_q;
            end else if (do_rest) begin
                cur_q <= saved_q;
            end
        end
    end

    AST_PUSH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> (top == $past(top_dn)) && tags[top]); // R2
    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && tags[top_dn]) |=> ovf); // R3
    AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        do_pop |=> (top == $past(top_up)) && !tags[$past(top)]); // R4
    AST_INIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        do_init |=> (top == '0) && (tags == '0)); // R8
    AST_RESTORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        do_rest |=> ({top, tags} == $past(saved_q))); // R9
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf)); // R10
endmodule

// File: rtl/stk_bank_array.sv
// Module: stk_bank_array
// NB independent data arrays of DEPTH words, one write port shared by all
// banks (steered by bank number) and two read ports on the selected bank.
// Data is deliberately not reset: initialise and reset only touch tags.
module stk_bank_array #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int NB    = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_bank,
    input  logic [PW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [BW-1:0] rd_bank,
    input  logic [PW-1:0] rd_idx0,
    input  logic [PW-1:0] rd_idx1,
    output logic [W-1:0]  rd_data0,
    output logic [W-1:0]  rd_data1
);
    logic [W-1:0] rd0_b [NB];
    logic [W-1:0] rd1_b [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [W-1:0] mem [DEPTH];
        // Write only the addressed bank; others keep their contents.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == BW'(b))) begin
                mem[wr_idx] <= wr_data;
            end
        end
        assign rd0_b[b] = mem[rd_idx0];
        assign rd1_b[b] = mem[rd_idx1];
    end

    // Read mux onto the selected bank.
    always_comb begin
        rd_data0 = rd0_b[rd_bank];
        rd_data1 = rd1_b[rd_bank];
    end
endmodule

// File: rtl/stack_bank_file.sv
// Module: stack_bank_file (top)
// Stack-addressed register file: shared pointer/tag status word, per-bank
// data. Decodes one command per cycle, keeps the selected bank register.
// Assumes DEPTH is a power of two and NB fits in din.
module stack_bank_file #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int NB    = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  tos_data,
    output logic          tos_valid,
    output logic [BW-1:0] bank_sel,
    output logic          ovf_flag,
    output logic          unf_flag
);
    import stk_pkg::*;

    cmd_e             cmd_c;
    logic             do_push, do_pop, do_addp, do_bank, do_init, do_save, do_rest;
    logic [PW-1:0]    top, top_dn, top_up;
    logic [DEPTH-1:0] tags;
    logic [BW-1:0]    bank_q;
    logic [W-1:0]     st0, st1;
    logic             wr_en;
    logic [PW-1:0]    wr_idx;
    logic [W-1:0]     wr_data;

    // Command decode into one-hot strobes.
    always_comb begin
        cmd_c   = cmd_e'(cmd);
        do_push = (cmd_c == CMD_PUSH);
        do_pop  = (cmd_c == CMD_POP);
        do_addp = (cmd_c == CMD_ADDP);
        do_bank = (cmd_c == CMD_BANK);
        do_init = (cmd_c == CMD_INIT);
        do_save = (cmd_c == CMD_SAVE);
        do_rest = (cmd_c == CMD_RESTORE);
    end

    // Selected bank register, changed only by bank select.
    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else if (do_bank) bank_q <= din[BW-1:0];
    end

    // Data write steering: push writes below top, add writes the next slot.
    always_comb begin
        wr_en   = do_push | do_addp;
        wr_idx  = do_push ? top_dn : top_up;
        wr_data = do_push ? din : (st0 + st1);
    end

    stk_status_ctl #(.DEPTH(DEPTH)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .do_push(do_push), .do_pop(do_pop), .do_addp(do_addp),
        .do_init(do_init), .do_save(do_save), .do_rest(do_rest),
        .top(top), .top_dn(top_dn), .top_up(top_up), .tags(tags),
        .ovf(ovf_flag), .unf(unf_flag)
    );

    stk_bank_array #(.W(W), .DEPTH(DEPTH), .NB(NB)) u_data (
        .clk(clk), .wr_en(wr_en), .wr_bank(bank_q), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_bank(bank_q), .rd_idx0(top), .rd_idx1(top_up),
        .rd_data0(st0), .rd_data1(st1)
    );

    assign tos_data  = st0;
    assign tos_valid = tags[top];
    assign bank_sel  = bank_q;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !do_bank |=> $stable(bank_q)); // R6
    AST_BANK_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        do_bank |=> $stable(top) && $stable(tags)); // R6
    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (do_addp && tags[top] && tags[top_up]) |=> (tos_data == $past(st0 + st1)) && tos_valid); // R5
    AST_NOP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_c == CMD_NOP) |=> $stable(top) && $stable(tags) && $stable(tos_data)); // R10
endmodule

// File: tb/sim_stack_bank_file.sv
// Bench: behavioural reference model (arrays, integers) compared every cycle.
module sim_stack_bank_file;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   cmd = 3'd0;
    logic [W-1:0] din = '0;
    logic [W-1:0] tos_data;
    logic         tos_valid;
    logic [1:0]   bank_sel;
    logic         ovf_flag, unf_flag;

    int checks = 0;
    int errors = 0;

    // model state
    logic [W-1:0] m_mem   [4][8];
    bit           m_known [4][8];
    bit           m_tag   [8];
    int           m_top, m_bank, m_stop;
    bit           m_stag  [8];
    bit           m_ovf, m_unf;

    always #5 clk = ~clk;

    stack_bank_file u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .din(din),
        .tos_data(tos_data), .tos_valid(tos_valid), .bank_sel(bank_sel),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "tos_valid", tos_valid, m_tag[m_top]);
        chk(req, "bank_sel", bank_sel, m_bank);
        chk(req, "ovf_flag", ovf_flag, m_ovf);
        chk(req, "unf_flag", unf_flag, m_unf);
        if (m_tag[m_top] && m_known[m_bank][m_top])
            chk(req, "tos_data", tos_data, m_mem[m_bank][m_top]);
    endtask

    task automatic model_step(input int c, input logic [W-1:0] d);
        int t1;
        m_ovf = 0; m_unf = 0;
        t1 = (m_top + 1) % 8;
        case (c)
            1: begin
                m_top = (m_top + 7) % 8;
                m_ovf = m_tag[m_top];
                m_mem[m_bank][m_top] = d;
                m_known[m_bank][m_top] = 1;
                m_tag[m_top] = 1;
            end
            2: begin
                m_unf = !m_tag[m_top];
                m_tag[m_top] = 0;
                m_top = t1;
            end
            3: begin
                m_unf = !m_tag[m_top] || !m_tag[t1];
                m_known[m_bank][t1] = m_known[m_bank][t1] && m_known[m_bank][m_top];
                m_mem[m_bank][t1] = m_mem[m_bank][t1] + m_mem[m_bank][m_top];
                m_tag[m_top] = 0;
                m_top = t1;
            end
            4: m_bank = int'(d[1:0]);
            5: begin
                m_top = 0;
                foreach (m_tag[i]) m_tag[i] = 0;
            end
            6: begin
                m_stop = m_top;
                foreach (m_tag[i]) m_stag[i] = m_tag[i];
            end
            7: begin
                m_top = m_stop;
                foreach (m_tag[i]) m_tag[i] = m_stag[i];
            end
            default: ;
        endcase
    endtask

    // Drive at the falling edge, let one rising edge act, compare at the next falling edge.
    task automatic do_cmd(input int c, input logic [W-1:0] d, input string req);
        cmd = 3'(c);
        din = d;
        @(posedge clk);
        model_step(c, d);
        @(negedge clk);
        cmd = 3'd0;
        compare_all(req);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_top = 0; m_bank = 0; m_stop = 0; m_ovf = 0; m_unf = 0;
        foreach (m_tag[i]) begin m_tag[i] = 0; m_stag[i] = 0; end
        for (int b = 0; b < 4; b++) for (int i = 0; i < 8; i++) begin
            m_known[b][i] = 0; m_mem[b][i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");
        chk("R1", "reset tos_valid", tos_valid, 0);
        chk("R1", "reset bank", bank_sel, 0);

        // directed: bank 1 holds three values, status saved
        do_cmd(4, 16'd1, "R6");
        do_cmd(1, 16'd10, "R2");
        do_cmd(1, 16'd20, "R2");
        do_cmd(1, 16'd30, "R2");
        chk("R2", "tos after pushes", tos_data, 30);
        do_cmd(6, 16'd0, "R9");
        do_cmd(4, 16'd2, "R6");
        chk("R6", "tag kept across switch", tos_valid, 1);
        do_cmd(5, 16'd0, "R8");
        chk("R8", "init empties top", tos_valid, 0);
        do_cmd(1, 16'd7, "R2");
        do_cmd(1, 16'd5, "R2");
        do_cmd(3, 16'd0, "R5");
        chk("R5", "sum 7+5", tos_data, 12);
        chk("R5", "no underflow", unf_flag, 0);
        do_cmd(2, 16'd0, "R4");
        do_cmd(4, 16'd1, "R7");
        chk("R7", "bank1 still empty view", tos_valid, 0);
        do_cmd(7, 16'd0, "R9");
        chk("R9", "restored top", tos_data, 30);
        do_cmd(2, 16'd0, "R9");
        chk("R9", "second in order", tos_data, 20);
        do_cmd(2, 16'd0, "R9");
        chk("R9", "third in order", tos_data, 10);
        do_cmd(0, 16'd0, "R10");
        chk("R10", "nop holds", tos_data, 10);

        // overflow: nine pushes after init
        do_cmd(5, 16'd0, "R8");
        for (int i = 0; i < 8; i++) do_cmd(1, 16'(100 + i), "R2");
        chk("R3", "no ovf at 8th", ovf_flag, 0);
        do_cmd(1, 16'd999, "R3");
        chk("R3", "ovf at 9th", ovf_flag, 1);
        chk("R3", "written anyway", tos_data, 999);
        do_cmd(0, 16'd0, "R3");
        chk("R3", "ovf one cycle", ovf_flag, 0);

        // underflow on empty stack
        do_cmd(5, 16'd0, "R8");
        do_cmd(2, 16'd0, "R4");
        chk("R4", "pop empty unf", unf_flag, 1);
        do_cmd(5, 16'd0, "R8");
        do_cmd(1, 16'd3, "R2");
        do_cmd(3, 16'd0, "R5");
        chk("R5", "add with one entry unf", unf_flag, 1);
        do_cmd(4, 16'd3, "R6");
        chk("R6", "scratch bank selectable", bank_sel, 3);

        // random run
        for (int n = 0; n < 3000; n++) begin
            int r, c;
            r = int'($urandom_range(0, 99));
            if (r < 35) c = 1;
            else if (r < 60) c = 2;
            else if (r < 72) c = 3;
            else if (r < 80) c = 4;
            else if (r < 84) c = 5;
            else if (r < 89) c = 6;
            else if (r < 94) c = 7;
            else c = 0;
            do_cmd(c, 16'($urandom), "R7");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule